// File: doc/BRIEF.md
# Vertical Countdown Sync Processor

This block produces the vertical drive pulse for a 525-line raster from a half-line clock enable that pulses at twice the line rate. A field counter advances on each enable pulse. Incoming vertical sync is edge-detected and then tested against an acceptance window whose limits a select pin picks. Sync that falls outside the window is discarded.

The block has two lock modes. In the locked countdown mode the field always restarts at count 525, and sync is used only to tell whether the countdown agrees with the incoming signal. A run of eight fields in which sync never lands on count 525 moves the block to the sync-triggered mode. In that mode an accepted sync restarts the field at once, and with no sync the field free-runs to the window's closing count. Eight fields in a row whose sync lands exactly on count 525 bring the block back to locked countdown.

All pins are plain control and status levels sampled on one clock. There is no data stream at the edge, so no valid/ready handshake is used.

Top module: `vcount_sync`

## Requirements
- R1: The field count k is the number of `tick` pulses since the last restart. Cycles with `tick` low change neither the count nor the mode.
- R2: With `win_sel` low, the window covers k = 464 to 592 inclusive. `win_open` is high while the next tick's k lies inside the current window.
- R3: With `win_sel` high, the window covers k = 512 to 568 inclusive. `win_open` follows the same rule as in R2.
- R4: In locked mode (`nonstd_mode` = 0), the field restarts at k = 525 whether or not sync is present.
- R5: In locked mode, every field that ends without a sync edge at k = 525 counts as a miss. The eighth consecutive miss sets `nonstd_mode` to 1. A coincident sync clears the miss run.
- R6: In sync-triggered mode (`nonstd_mode` = 1), an accepted sync edge restarts the field on the tick at which it is taken.
- R7: In sync-triggered mode with no accepted sync, the field restarts on the first tick whose k reaches the window's closing count: 592 with `win_sel` low, 568 with `win_sel` high.
- R8: Sync outside the window is ignored in both modes. A rising edge of `vsync_in` is held until the next tick and counts once, however long the level stays high.
- R9: In sync-triggered mode, eight consecutive fields ended by sync at k = 525 return `nonstd_mode` to 0. A field ended any other way clears the run.
- R10: `vdrive` rises in the cycle after a restart tick and stays high for 6 ticks.
- R11: While `rst_n` is low, the block is in locked mode with the count at 0, `vdrive` low and `win_open` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Half-line (2fH) clock enable |
| vsync_in | input | 1 | Vertical sync level, synchronous to clk |
| win_sel | input | 1 | Window select: 0 = wide, 1 = narrow |
| vdrive | output | 1 | Vertical drive / reset pulse |
| nonstd_mode | output | 1 | 1 = sync-triggered mode |
| win_open | output | 1 | Next tick falls inside the acceptance window |

## Verification
The stimulus places sync on count 525, inside the window away from 525, exactly on both window edges, just outside the window, and not at all. Between them these cases separate a countdown restart, a sync-triggered restart and a free-run restart. Miss and coincidence runs stop at seven, are broken by one opposite field, and then run to eight, which shows that the run counters clear and that the mode switches on exactly the eighth field. A sync level held high across a whole field shows whether the edge detector fires once or keeps retriggering.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic {VM_LOCK = 1'b0, VM_FREE = 1'b1} vmode_e;
endpackage

// File: rtl/vc_window.sv
module vc_window #(
  parameter int CW       = 10,
  parameter int LINES    = 525,
  parameter int LO_OPEN  = 464,
  parameter int LO_CLOSE = 592,
  parameter int HI_OPEN  = 512,
  parameter int HI_CLOSE = 568
) (
  input  logic [CW-1:0] cnt,
  input  logic          sel,
  output logic          in_win,
  output logic          at_line,
  output logic          at_close
);
  localparam int NSET = 2;
  logic [CW-1:0] k;
  logic [NSET-1:0] in_t, close_t;

  assign k = cnt + 1'b1;

  // one comparator pair per selectable window setting
  for (genvar g = 0; g < NSET; g++) begin : g_set
    localparam int OPN = (g == 0) ? LO_OPEN  : HI_OPEN;
    localparam int CLS = (g == 0) ? LO_CLOSE : HI_CLOSE;
    assign in_t[g]    = (k >= CW'(OPN)) && (k <= CW'(CLS));
    assign close_t[g] = (k >= CW'(CLS));
  end

  assign in_win   = in_t[sel];
  assign at_close = close_t[sel];
  assign at_line  = (k == CW'(LINES));
endmodule

// File: rtl/vc_mode.sv
module vc_mode
  import vc_pkg::*;
#(
  parameter int RUN_FIELDS = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   sync_ok,
  input  logic   at_line,
  input  logic   at_close,
  output logic   restart,
  output vmode_e mode
);
  localparam int SW = (RUN_FIELDS > 1) ? $clog2(RUN_FIELDS) : 1;
  localparam logic [SW-1:0] LAST = SW'(RUN_FIELDS - 1);

  logic [SW-1:0] run_q, run_d;
  vmode_e mode_d;

  always_comb begin
    restart = 1'b0;
    run_d   = run_q;
    mode_d  = mode;
    if (tick) begin
      if (mode == VM_LOCK) begin
        if (at_line) begin
          restart = 1'b1;
          if (sync_ok) run_d = '0;
          else if (run_q == LAST) begin
            run_d  = '0;
            mode_d = VM_FREE;
          end else run_d = run_q + 1'b1;
        end
      end else begin
        if (sync_ok) begin
          restart = 1'b1;
          if (!at_line) run_d = '0;
          else if (run_q == LAST) begin
            run_d  = '0;
            mode_d = VM_LOCK;
          end else run_d = run_q + 1'b1;
        end else if (at_close) begin
          restart = 1'b1;
          run_d   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      mode  <= VM_LOCK;
    end else begin
      run_q <= run_d;
      mode  <= mode_d;
    end
  end

  p_mode_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mode));
  p_hit_keeps_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == VM_LOCK && at_line && sync_ok) |=> mode == VM_LOCK);
  p_free_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == VM_FREE && restart && !at_line) |=> mode == VM_FREE);
endmodule

// File: rtl/vc_pulse.sv
module vc_pulse #(
  parameter int PULSE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic vdrive
);
  localparam int PW = $clog2(PULSE_W + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) left_q <= '0;
    else if (restart) left_q <= PW'(PULSE_W);
    else if (tick && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign vdrive = (left_q != '0);

  p_drive_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> vdrive);
endmodule

// File: rtl/vcount_sync.sv
module vcount_sync
  import vc_pkg::*;
#(
  parameter int CW         = 10,
  parameter int LINES      = 525,
  parameter int LO_OPEN    = 464,
  parameter int LO_CLOSE   = 592,
  parameter int HI_OPEN    = 512,
  parameter int HI_CLOSE   = 568,
  parameter int RUN_FIELDS = 8,
  parameter int PULSE_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic vsync_in,
  input  logic win_sel,
  output logic vdrive,
  output logic nonstd_mode,
  output logic win_open
);
  localparam int MAXC = (LO_CLOSE > HI_CLOSE) ? LO_CLOSE : HI_CLOSE;

  logic [CW-1:0] cnt;
  logic vs_q, pend, rise, sync_ok, restart;
  logic at_line, at_close, in_win;
  vmode_e mode;

  assign rise    = vsync_in & ~vs_q;
  assign sync_ok = tick & (pend | rise) & in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q <= 1'b0;
      pend <= 1'b0;
      cnt  <= '0;
    end else begin
      vs_q <= vsync_in;
      if (tick) pend <= 1'b0;
      else if (rise) pend <= 1'b1;
      if (tick) cnt <= restart ? '0 : cnt + 1'b1;
    end
  end

  vc_window #(.CW(CW), .LINES(LINES), .LO_OPEN(LO_OPEN), .LO_CLOSE(LO_CLOSE),
              .HI_OPEN(HI_OPEN), .HI_CLOSE(HI_CLOSE)) u_win (
    .cnt(cnt), .sel(win_sel), .in_win(in_win), .at_line(at_line), .at_close(at_close));

  vc_mode #(.RUN_FIELDS(RUN_FIELDS)) u_mode (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sync_ok(sync_ok), .at_line(at_line),
    .at_close(at_close), .restart(restart), .mode(mode));

  vc_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .vdrive(vdrive));

  assign nonstd_mode = (mode == VM_FREE);
  assign win_open    = in_win;

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  p_lock_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nonstd_mode && restart) |-> cnt == CW'(LINES - 1));
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(MAXC));
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
endmodule

// File: tb/sim_vcount_sync.sv
module sim_vcount_sync;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, vsync_in = 1'b0, win_sel = 1'b0;
  logic vdrive, nonstd_mode, win_open;

  always #2.5 clk = ~clk;

  vcount_sync u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .vsync_in(vsync_in),
    .win_sel(win_sel), .vdrive(vdrive), .nonstd_mode(nonstd_mode), .win_open(win_open));

  int n_vec = 0, n_bad = 0, tn = 0;
  int exp_q[$];
  string req_q[$];
  int mk = 0, mrun = 0, mp = 0;
  bit mfree = 0, mprev = 0, vprev = 0, done = 0;

  task automatic chk(input int act, input int exp, input string req);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp, tn);
    end
  endtask

  function automatic int opn(); return win_sel ? 512 : 464; endfunction
  function automatic int cls(); return win_sel ? 568 : 592; endfunction

  // reference step from the requirements; returns restart flag
  function automatic bit step(input bit lvl, output string why);
    bit s, r; int k;
    s = lvl && !mprev; mprev = lvl; r = 0; why = "";
    mk++; k = mk;
    s = s && (k >= opn()) && (k <= cls());
    if (!mfree) begin
      if (k == 525) begin
        r = 1; why = "R4";
        if (s) mrun = 0;
        else if (mrun == 7) begin mrun = 0; mfree = 1; end
        else mrun++;
      end
    end else if (s) begin
      r = 1; why = "R6";
      if (k != 525) mrun = 0;
      else if (mrun == 7) begin mrun = 0; mfree = 0; end
      else mrun++;
    end else if (k >= cls()) begin
      r = 1; why = "R7"; mrun = 0;
    end
    if (r) begin mk = 0; mp = 6; end
    else if (mp > 0) mp--;
    return r;
  endfunction

  task automatic do_tick(input bit lvl, output bit rs);
    string why;
    int k1;
    @(negedge clk);
    k1 = mk + 1;
    chk(vdrive, (mp != 0), "R10");
    chk(nonstd_mode, mfree, mfree ? "R9" : "R5");
    chk(win_open, (k1 >= opn() && k1 <= cls()), win_sel ? "R3" : "R2");
    vsync_in = lvl;
    @(negedge clk);
    tick = 1'b1;
    tn++;
    rs = step(lvl, why);
    if (rs) begin exp_q.push_back(tn); req_q.push_back(why); end
    @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic field(input int at, input int exp_len, input string req);
    bit r = 0;
    int len = 0;
    while (!r) begin
      len++;
      do_tick(len == at, r);
    end
    chk(len, exp_len, req);
  endtask

  // scoreboard monitor: each rising vdrive pops one expected restart
  always @(negedge clk) begin
    if (rst_n && vdrive && !vprev) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R8: actual restart at tick %0d expected none", tn);
      end else begin
        int e;
        string q;
        e = exp_q.pop_front();
        q = req_q.pop_front();
        chk(tn, e, q);
      end
    end
    vprev = vdrive;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R1: watchdog expired, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit r;
    int len;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(vdrive, 0, "R11");
    chk(nonstd_mode, 0, "R11");
    chk(win_open, 0, "R11");
    rst_n = 1'b1;
    // locked mode with coincident sync
    repeat (3) field(525, 525, "R4");
    // seven misses keep lock, the eighth switches
    repeat (7) field(0, 525, "R4");
    @(negedge clk); chk(nonstd_mode, 0, "R5");
    field(0, 525, "R5");
    @(negedge clk); chk(nonstd_mode, 1, "R5");
    // free-run at each window close
    field(0, 592, "R7");
    win_sel = 1'b1;
    field(0, 568, "R7");
    field(530, 530, "R6");
    field(300, 568, "R8");
    field(580, 568, "R8");
    win_sel = 1'b0;
    field(470, 470, "R6");
    field(464, 464, "R2");
    field(463, 592, "R8");
    field(592, 592, "R2");
    // level held high: one edge, one restart
    for (int i = 1; i < 470; i++) do_tick(1'b0, r);
    do_tick(1'b1, r);
    chk(r, 1, "R8");
    len = 0;
    for (int i = 0; i < 199; i++) begin do_tick(1'b1, r); len++; end
    r = 0;
    while (!r) begin do_tick(1'b0, r); len++; end
    chk(len, 592, "R8");
    // return to lock: run broken once, then eight
    repeat (7) field(525, 525, "R9");
    field(500, 500, "R9");
    repeat (7) field(525, 525, "R9");
    @(negedge clk); chk(nonstd_mode, 1, "R9");
    field(525, 525, "R9");
    @(negedge clk); chk(nonstd_mode, 0, "R9");
    // locked: in-window non-coincident sync ignored, coincidence clears run
    field(480, 525, "R8");
    field(525, 525, "R5");
    win_sel = 1'b1;
    repeat (7) field(0, 525, "R5");
    @(negedge clk); chk(nonstd_mode, 0, "R5");
    repeat (10) do_tick(1'b0, r);
    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule